// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog

This block is a system timer placed on a simple synchronous register bus. A single 32-bit up-counter advances by one on every cycle in which the tick-enable input is high. Four compare registers are checked against the value the counter is about to take. When one of them matches and that channel is enabled, the channel's pending flag is set and its interrupt line goes high. The line stays high until software clears the flag by writing a one to its status bit.

Channel 3 can also act as a watchdog. When the watchdog-enable bit is set, a channel-3 match produces a single-cycle reset-request pulse, whether or not the channel's interrupt is enabled. Software keeps the system alive by rewriting the counter or the channel-3 compare value before the match occurs. Register reads return data one cycle after the request. Any unmapped or misaligned offset reads as zero and raises a one-cycle error flag.

Top module: `match_timer`

## Requirements
- R1: Byte offsets: compare register n at 4*n (n = 0..3), counter at 0x10, status at 0x14 (bits 3:0 = flags of channels 3..0), watchdog enable at 0x18 (bit 0), interrupt enable at 0x1C. Read data appears on the port in the cycle after the read request.
- R2: Writing the counter loads the written value and counting continues from it. A counter write in a tick cycle takes the written value without incrementing.
- R3: The interrupt-enable register holds bits 11:0. Written bits above bit 11 are dropped and read back as zero.
- R4: A match on channel n sets flag n and raises irq[n] (irq[n] mirrors flag n) only if enable bit n is 1. With enable bit n at 0, flag n stays unchanged.
- R5: Writing the status register with bit n = 1 clears flag n and lowers irq[n]. Bits written as 0 leave their flags unchanged.
- R6: With watchdog enable bit 0 set, a channel-3 match drives wdt_reset_req high for exactly one cycle, independent of the channel-3 interrupt enable. With watchdog enable clear, no request is made.
- R7: Writing a compare register replaces its value, and only the new value matches afterwards.
- R8: If a match sets flag n in the same cycle as a status write that clears it, the flag ends up set.
- R9: A match is the tick on which counter+1 equals the compare value. The counter wraps from 0xFFFFFFFF to 0.
- R10: A read of an unmapped or misaligned offset returns 0 and raises bus_rerr for one cycle. Mapped reads leave bus_rerr low.
- R11: After reset, the counter, compare registers, flags, enables, irq, bus_rdata, bus_rerr and wdt_reset_req are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| bus_en | input | 1 | Bus request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rerr | output | 1 | One-cycle pulse on an unmapped read |
| irq | output | 4 | Per-channel interrupt lines |
| wdt_reset_req | output | 1 | One-cycle watchdog reset request |

## Verification
A match is registered at the edge of its tick cycle, so irq and wdt_reset_req change one edge after the tick and the pulse is gone one edge later. Register writes take effect at the edge of the request, and read data and the error flag appear one edge after the read request. The bench drives and samples on falling edges. After each stimulus it checks the output at the first falling edge where the result is due, and for pulses it checks again one cycle later.

// File: rtl/mtmr_pkg.sv
// Package: shared offsets and constants for the match timer.
// Assumes byte addressing with 32-bit aligned registers.
package mtmr_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned WDOG_CH  = 3;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_WDOG = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_IEN  = 8'h1C;
endpackage

// File: rtl/mtmr_counter.sv
// Free-running up-counter with load. A load has priority over a tick.
// Assumes the load and the tick are single-cycle qualified strobes.
module mtmr_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] ldata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             adv
);
    assign cnt_inc = cnt_q + CNT_W'(1);
    assign adv     = tick & ~load;

    // Counter register: reset, load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (load)  cnt_q <= ldata;
        else if (tick)  cnt_q <= cnt_inc;
    end
endmodule

// File: rtl/mtmr_channel.sv
// One compare channel: compare register, match detect and sticky flag.
// Assumes cnt_inc is the value the counter takes when adv is high.
module mtmr_channel #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt_inc,
    input  logic             wr_match,
    input  logic [CNT_W-1:0] wdata,
    input  logic             en,
    input  logic             clr,
    output logic [CNT_W-1:0] match_q,
    output logic             hit,
    output logic             flag_q
);
    assign hit = adv && (cnt_inc == match_q);

    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n)        match_q <= '0;
        else if (wr_match) match_q <= wdata;
    end

    // Sticky flag: an enabled match wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (hit && en) flag_q <= 1'b1;
        else if (clr)       flag_q <= 1'b0;
    end
endmodule

// File: rtl/mtmr_regif.sv
// Register interface: write decode, enable registers, registered read mux.
// Assumes one request per cycle; reads have one cycle of latency.
module mtmr_regif
    import mtmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned IEN_W  = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_en,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [CNT_W-1:0]             bus_wdata,
    input  logic [CNT_W-1:0]             cnt,
    input  logic [NUM_CH-1:0][CNT_W-1:0] match_vals,
    input  logic [NUM_CH-1:0]            status,
    output logic [NUM_CH-1:0]            wr_match,
    output logic                         wr_cnt,
    output logic [NUM_CH-1:0]            clr_stat,
    output logic [IEN_W-1:0]             ien_q,
    output logic                         wdog_q,
    output logic [CNT_W-1:0]             rdata_q,
    output logic                         rerr_q
);
    logic             wr_s, rd_s, mapped;
    logic [CNT_W-1:0] rd_word;

    assign wr_s = bus_en & bus_wr;
    assign rd_s = bus_en & ~bus_wr;

    // Write strobes for the compare registers, one per channel.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_wdec
        assign wr_match[n] = wr_s && (bus_addr == ADDR_W'(4 * n));
    end

    assign wr_cnt   = wr_s && (bus_addr == OFF_CNT);
    assign clr_stat = (wr_s && (bus_addr == OFF_STAT)) ? bus_wdata[NUM_CH-1:0] : '0;

    // Enable registers for interrupts and the watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            wdog_q <= 1'b0;
        end else if (wr_s) begin
            if (bus_addr == OFF_IEN)  ien_q  <= bus_wdata[IEN_W-1:0];
            if (bus_addr == OFF_WDOG) wdog_q <= bus_wdata[0];
        end
    end

    // Read selection and address-hit detection.
    always_comb begin
        mapped  = 1'b1;
        rd_word = '0;
        case (bus_addr)
            OFF_CNT:  rd_word = cnt;
            OFF_STAT: rd_word = CNT_W'(status);
            OFF_WDOG: rd_word = CNT_W'(wdog_q);
            OFF_IEN:  rd_word = CNT_W'(ien_q);
            default: begin
                mapped = 1'b0;
                for (int n = 0; n < NUM_CH; n++) begin
                    if (bus_addr == ADDR_W'(4 * n)) begin
                        mapped  = 1'b1;
                        rd_word = match_vals[n];
                    end
                end
            end
        endcase
    end

    // Registered read data and one-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rerr_q  <= 1'b0;
        end else begin
            rerr_q <= 1'b0;
            if (rd_s) begin
                rdata_q <= mapped ? rd_word : '0;
                rerr_q  <= ~mapped;
            end
        end
    end
endmodule

// File: rtl/match_timer.sv
// Top: counter, four compare channels, register interface, watchdog request.
// Assumes tick_en is synchronous to clk; irq lines mirror the sticky flags.
module match_timer
    import mtmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned IEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rerr,
    output logic [3:0]        irq,
    output logic              wdt_reset_req
);
    logic [CNT_W-1:0]             cnt_q, cnt_inc;
    logic                         adv, wr_cnt, wdog_q;
    logic [NUM_CH-1:0]            wr_match, clr_stat, hit, flag_q;
    logic [NUM_CH-1:0][CNT_W-1:0] match_vals;
    logic [IEN_W-1:0]             ien_q;

    mtmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .load(wr_cnt),
        .ldata(bus_wdata), .cnt_q(cnt_q), .cnt_inc(cnt_inc), .adv(adv)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        mtmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .adv(adv), .cnt_inc(cnt_inc),
            .wr_match(wr_match[n]), .wdata(bus_wdata), .en(ien_q[n]),
            .clr(clr_stat[n]), .match_q(match_vals[n]), .hit(hit[n]),
            .flag_q(flag_q[n])
        );
    end

    mtmr_regif #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .IEN_W(IEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q),
        .match_vals(match_vals), .status(flag_q), .wr_match(wr_match),
        .wr_cnt(wr_cnt), .clr_stat(clr_stat), .ien_q(ien_q), .wdog_q(wdog_q),
        .rdata_q(bus_rdata), .rerr_q(bus_rerr)
    );

    assign irq = flag_q;

    // Watchdog request: one-cycle pulse on a channel-3 match when armed.
    always_ff @(posedge clk) begin
        if (!rst_n) wdt_reset_req <= 1'b0;
        else        wdt_reset_req <= wdog_q & hit[WDOG_CH];
    end
endmodule

// File: rtl/match_timer_checker.sv
// Checker: temporal properties of the match timer, bound to the top.
// Assumes the reset is held for at least one clock edge at start-up.
module match_timer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        bus_en,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_rerr,
    input logic [3:0]  irq,
    input logic        wdt_reset_req,
    input logic [31:0] cnt,
    input logic [11:0] ien,
    input logic        wdog_en
);
    logic cnt_wr, stat_wr;
    assign cnt_wr  = bus_en && bus_wr && (bus_addr == 8'h10);
    assign stat_wr = bus_en && bus_wr && (bus_addr == 8'h14);

    // R2 / R9: a tick without a load advances the counter by one (with wrap).
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tick_en) && !$past(cnt_wr) |-> cnt == $past(cnt) + 32'd1);

    // R2: a counter write loads the written value.
    assert_count_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cnt_wr) |-> cnt == $past(bus_wdata));

    for (genvar n = 0; n < 4; n++) begin : g_chk
        // R4: an interrupt line rises only for an enabled channel.
        assert_rise_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(irq[n]) && irq[n] |-> $past(ien[n]));
        // R5: an interrupt line falls only on a status write with its bit set.
        assert_fall_needs_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(irq[n]) && !irq[n] |-> $past(stat_wr) && $past(bus_wdata[n]));
    end

    // R6: a reset request only follows an armed watchdog.
    assert_wdt_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |-> $past(wdog_en) && $past(rst_n));

    // R10: the error flag only follows a read request.
    assert_rerr_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rerr |-> $past(bus_en) && !$past(bus_wr) && $past(rst_n));
endmodule

bind match_timer match_timer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rerr(bus_rerr), .irq(irq), .wdt_reset_req(wdt_reset_req),
    .cnt(cnt_q), .ien(ien_q), .wdog_en(wdog_q)
);

// File: tb/match_timer_test.sv
module match_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rerr;
    logic [3:0]  irq;
    logic        wdt_reset_req;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    match_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rerr(bus_rerr), .irq(irq),
        .wdt_reset_req(wdt_reset_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; e = bus_rerr;
        bus_en = 1'b0;
    endtask

    task automatic tick(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic e;
        chk("R11 irq", 32'(irq), 0);
        chk("R11 wdt_reset_req", 32'(wdt_reset_req), 0);
        chk("R11 bus_rerr", 32'(bus_rerr), 0);
        chk("R11 bus_rdata", bus_rdata, 0);
        for (int a = 0; a < 32; a += 4) begin
            rd(8'(a), d, e);
            chk("R11 register zero", d, 0);
            chk("R11 mapped read no error", 32'(e), 0);
        end
    endtask

    task automatic t_offsets;
        logic [31:0] d; logic e;
        for (int n = 0; n < 4; n++) wr(8'(4 * n), 32'hA000_0000 + 32'(n));
        for (int n = 0; n < 4; n++) begin
            rd(8'(4 * n), d, e);
            chk("R1 compare readback", d, 32'hA000_0000 + 32'(n));
        end
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d, e);
        chk("R1 watchdog enable bit 0 only", d, 1);
        wr(8'h18, 0);
        for (int n = 0; n < 4; n++) wr(8'(4 * n), 0);
    endtask

    task automatic t_counter;
        logic [31:0] d; logic e;
        wr(8'h10, 32'h100);
        rd(8'h10, d, e);
        chk("R2 counter load", d, 32'h100);
        tick(5);
        rd(8'h10, d, e);
        chk("R2 counting continues from load", d, 32'h105);
        wr(8'h10, 32'hFFFF_FFFF);
        tick(1);
        rd(8'h10, d, e);
        chk("R9 counter wraps to zero", d, 0);
        @(negedge clk);
        tick_en = 1'b1; bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h200;
        @(negedge clk);
        tick_en = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
        rd(8'h10, d, e);
        chk("R2 load beats tick", d, 32'h200);
    endtask

    task automatic t_ien_width;
        logic [31:0] d; logic e;
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, d, e);
        chk("R3 enable holds 12 bits", d, 32'h0000_0FFF);
        wr(8'h1C, 0);
    endtask

    task automatic t_match_enabled;
        logic [31:0] d; logic e;
        wr(8'h00, 32'h50);
        wr(8'h1C, 32'h1);
        wr(8'h10, 32'h4E);
        tick(1);
        chk("R9 no match before compare value", 32'(irq), 0);
        tick(1);
        chk("R4 enabled match raises irq0", 32'(irq), 32'h1);
        rd(8'h14, d, e);
        chk("R4 status bit 0 set", d, 32'h1);
    endtask

    task automatic t_match_disabled;
        logic [31:0] d; logic e;
        wr(8'h04, 32'h60);
        wr(8'h10, 32'h5F);
        tick(1);
        chk("R4 disabled channel no irq1", 32'(irq), 32'h1);
        rd(8'h14, d, e);
        chk("R4 disabled channel status unchanged", d, 32'h1);
    endtask

    task automatic t_clear;
        logic [31:0] d; logic e;
        wr(8'h14, 32'h0);
        chk("R5 zero write leaves flag", 32'(irq), 32'h1);
        wr(8'h14, 32'hE);
        chk("R5 other bits leave flag", 32'(irq), 32'h1);
        wr(8'h14, 32'h1);
        chk("R5 write one clears irq0", 32'(irq), 0);
        rd(8'h14, d, e);
        chk("R5 status cleared", d, 0);
    endtask

    task automatic t_set_beats_clear;
        wr(8'h10, 32'h4F);
        tick(1);
        chk("R8 flag set again", 32'(irq), 32'h1);
        wr(8'h10, 32'h4F);
        @(negedge clk);
        tick_en = 1'b1; bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1;
        @(negedge clk);
        tick_en = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
        chk("R8 match wins over clear", 32'(irq), 32'h1);
        wr(8'h14, 32'hF);
        wr(8'h1C, 0);
    endtask

    task automatic t_rewrite;
        wr(8'h08, 32'h70);
        wr(8'h1C, 32'h4);
        wr(8'h08, 32'h80);
        wr(8'h10, 32'h6F);
        tick(1);
        chk("R7 old compare value ignored", 32'(irq), 0);
        wr(8'h10, 32'h7F);
        tick(1);
        chk("R7 new compare value matches", 32'(irq), 32'h4);
        wr(8'h14, 32'h4);
        wr(8'h1C, 0);
    endtask

    task automatic t_watchdog;
        wr(8'h0C, 32'h90);
        wr(8'h10, 32'h8F);
        tick(1);
        chk("R6 no request when disarmed", 32'(wdt_reset_req), 0);
        wr(8'h18, 32'h1);
        wr(8'h10, 32'h8F);
        tick(1);
        chk("R6 request pulse high", 32'(wdt_reset_req), 1);
        chk("R6 irq3 stays low when not enabled", 32'(irq), 0);
        @(negedge clk);
        chk("R6 request lasts one cycle", 32'(wdt_reset_req), 0);
        wr(8'h18, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d; logic e;
        rd(8'h20, d, e);
        chk("R10 unmapped reads zero", d, 0);
        chk("R10 unmapped raises error", 32'(e), 1);
        @(negedge clk);
        chk("R10 error lasts one cycle", 32'(bus_rerr), 0);
        rd(8'h12, d, e);
        chk("R10 misaligned raises error", 32'(e), 1);
        chk("R10 misaligned reads zero", d, 0);
        rd(8'h0C, d, e);
        chk("R10 mapped read no error", 32'(e), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_offsets();
        t_counter();
        t_ien_width();
        t_match_enabled();
        t_match_disabled();
        t_clear();
        t_set_beats_clear();
        t_rewrite();
        t_watchdog();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule